// File: doc/BRIEF.md
# Multi-period reference frequency monitor

This block judges whether a single reference clock is usable by timing a long run of its cycles against a fixed local measurement clock. The reference arrives already synchronized into the measurement domain as a one-cycle pulse per reference edge. Starting at one reference edge, the block counts measurement-clock cycles until a programmed number of further reference edges has gone by. The next window begins on that same edge, so there is no dead time between windows. The finished count is then sorted into one of three zones: in band, grey zone, or out of band. Four limits, two near and two far, set the zone edges.

A status flag reports valid or failed. A valid reference is failed only by counts beyond a far limit. A failed reference is restored only by counts inside the near limits. Counts in the grey zone between a near and a far limit change nothing. The flag moves only after two consecutive measurements that both call for the same change. A single enable selects between the programmed settings and built-in defaults. The defaults give a window of about ten seconds for an 8 kHz reference, against a 100 MHz measurement clock. If reference edges stop, the measurement counter saturates, and that counts as a measurement that is too long.

Top module: `mp_ref_monitor`

## Requirements
- R1: While rst_ni is low and after its release, valid_o, done_o and chg_o are 0 (status failed).
- R2: A window begins on a sampled ref_pulse_i. It ends on the Nth later pulse, where N = {win_u_i, win_l_i} and N = 0 acts as 1. The ending pulse also starts the next window. The measured value is the number of clock edges from the start pulse to the end pulse. done_o is high for exactly one cycle, beginning two rising edges after the edge that samples the ending pulse.
- R3: A valid status becomes failed only after two consecutive measurements, each either greater than the far upper limit or less than the far lower limit. A value equal to a far limit does not count as out of band.
- R4: A failed status becomes valid only after two consecutive measurements with near lower <= value <= near upper (both bounds inclusive).
- R5: A measurement in the grey zone, or one that agrees with the current status, leaves the status unchanged and breaks any run of consecutive votes.
- R6: valid_o changes only in a cycle where done_o is high. chg_o is high for one cycle exactly when valid_o has just toggled.
- R7: When use_prog_i is 0, the programmed window and limits are ignored and the parameter defaults are used.
- R8: If the measurement counter reaches 2^CNT_W-1 with no ending pulse, the measurement ends as out of band above the far upper limit. A new window restarts on that same edge without needing a reference pulse.
- R9: Settings are sampled on the edge that starts a window. A change made during a window affects only the following window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Measurement clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_pulse_i | input | 1 | One-cycle pulse per reference edge, synchronized |
| use_prog_i | input | 1 | 1 selects programmed settings, 0 selects defaults |
| win_l_i | input | 16 | Window length in reference cycles, lower half |
| win_u_i | input | 16 | Window length, upper half |
| nhi_l_i | input | 16 | Near upper limit, lower half |
| nhi_u_i | input | 16 | Near upper limit, upper half |
| fhi_l_i | input | 16 | Far upper limit, lower half |
| fhi_u_i | input | 16 | Far upper limit, upper half |
| nlo_l_i | input | 16 | Near lower limit, lower half |
| nlo_u_i | input | 16 | Near lower limit, upper half |
| flo_l_i | input | 16 | Far lower limit, lower half |
| flo_u_i | input | 16 | Far lower limit, upper half |
| valid_o | output | 1 | 1 when the reference is judged valid |
| done_o | output | 1 | One-cycle strobe per finished measurement |
| chg_o | output | 1 | One-cycle strobe when valid_o toggles |

## Verification
The close of one window and the opening of the next fall on the same clock edge. On that edge the finished count must be judged against the old limits, while the new settings are loaded for the coming window. The bench provokes this by rewriting the window length in the middle of a window. It then judges the result by the exact cycle of done_o: the current window must still end after the old number of edges, and the next window after the new number. The boundary counts in the vector table, which sit exactly on near and far limits, confirm that classification stays with the limits of the window that produced the count.

// File: rtl/mpm_pkg.sv
package mpm_pkg;
  localparam int unsigned CFG_W  = 32;
  localparam int unsigned HALF_W = CFG_W / 2;
  localparam int unsigned NFLD   = 5;
  localparam int unsigned F_WIN  = 0;
  localparam int unsigned F_NHI  = 1;
  localparam int unsigned F_FHI  = 2;
  localparam int unsigned F_NLO  = 3;
  localparam int unsigned F_FLO  = 4;

  typedef logic [NFLD-1:0][CFG_W-1:0] cfg_t;

  typedef enum logic [1:0] {
    ZONE_IN   = 2'd0,
    ZONE_GREY = 2'd1,
    ZONE_OUT  = 2'd2
  } zone_e;
endpackage

// File: rtl/mpm_cfg_sel.sv
module mpm_cfg_sel
  import mpm_pkg::*;
#(
  parameter cfg_t DEF_CFG = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              use_prog_i,
  input  logic [HALF_W-1:0] lo_half_i [NFLD],
  input  logic [HALF_W-1:0] hi_half_i [NFLD],
  output cfg_t              cfg_o
);
  cfg_t prog_w;
  cfg_t cfg_q;

  for (genvar f = 0; f < NFLD; f++) begin : g_fld
    assign prog_w[f] = {hi_half_i[f], lo_half_i[f]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= DEF_CFG;
    else if (load_i) cfg_q <= use_prog_i ? prog_w : DEF_CFG;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/mpm_window_ctr.sv
module mpm_window_ctr
  import mpm_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_pulse_i,
  input  logic [CFG_W-1:0] win_i,
  output logic             start_o,
  output logic             done_o,
  output logic             sat_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             armed_q;
  logic [CFG_W-1:0] ref_q;
  logic [CNT_W-1:0] meas_q;
  logic [CFG_W:0]   win_eff;
  logic [CFG_W:0]   ref_next;
  logic             end_hit;
  logic             sat_hit;

  always_comb begin
    win_eff  = (win_i == '0) ? (CFG_W+1)'(1) : {1'b0, win_i};
    ref_next = {1'b0, ref_q} + (CFG_W+1)'(1);
    end_hit  = armed_q && ref_pulse_i && (ref_next >= win_eff);
    // saturation only when the window did not close this cycle
    sat_hit  = armed_q && !end_hit && (&meas_q);
    start_o  = (!armed_q && ref_pulse_i) || end_hit || sat_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      ref_q   <= '0;
      meas_q  <= '0;
    end else if (start_o) begin
      armed_q <= 1'b1;
      ref_q   <= '0;
      meas_q  <= CNT_W'(1);
    end else if (armed_q) begin
      meas_q <= meas_q + CNT_W'(1);
      if (ref_pulse_i) ref_q <= ref_q + CFG_W'(1);
    end
  end

  assign done_o = end_hit || sat_hit;
  assign sat_o  = sat_hit;
  assign cnt_o  = meas_q;
endmodule

// File: rtl/mpm_zone_cls.sv
module mpm_zone_cls
  import mpm_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             sat_i,
  input  logic [CFG_W-1:0] nhi_i,
  input  logic [CFG_W-1:0] fhi_i,
  input  logic [CFG_W-1:0] nlo_i,
  input  logic [CFG_W-1:0] flo_i,
  output zone_e            zone_o
);
  logic [CFG_W-1:0] val;

  always_comb begin
    val = CFG_W'(cnt_i);
    if (sat_i || (val > fhi_i) || (val < flo_i)) zone_o = ZONE_OUT;
    else if ((val >= nlo_i) && (val <= nhi_i))   zone_o = ZONE_IN;
    else                                         zone_o = ZONE_GREY;
  end
endmodule

// File: rtl/mpm_decision.sv
module mpm_decision
  import mpm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  meas_i,
  input  zone_e zone_i,
  output logic  valid_o,
  output logic  done_o,
  output logic  chg_o
);
  logic valid_q, pend_q, done_q, chg_q;
  logic vote;

  // a vote is a measurement that calls for leaving the present status
  assign vote = valid_q ? (zone_i == ZONE_OUT) : (zone_i == ZONE_IN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      chg_q   <= 1'b0;
    end else begin
      done_q <= meas_i;
      chg_q  <= 1'b0;
      if (meas_i) begin
        if (vote && pend_q) begin
          valid_q <= !valid_q;
          pend_q  <= 1'b0;
          chg_q   <= 1'b1;
        end else begin
          pend_q <= vote;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign done_o  = done_q;
  assign chg_o   = chg_q;
endmodule

// File: rtl/mp_ref_monitor.sv
module mp_ref_monitor
  import mpm_pkg::*;
#(
  parameter int unsigned      CNT_W   = 32,
  // defaults: 8 kHz reference, 10 s window, 100 MHz measurement clock
  parameter logic [CFG_W-1:0] DEF_WIN = 32'd80_000,
  parameter logic [CFG_W-1:0] DEF_NHI = 32'd1_000_009_200,
  parameter logic [CFG_W-1:0] DEF_FHI = 32'd1_000_012_000,
  parameter logic [CFG_W-1:0] DEF_NLO = 32'd999_990_800,
  parameter logic [CFG_W-1:0] DEF_FLO = 32'd999_988_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_pulse_i,
  input  logic              use_prog_i,
  input  logic [HALF_W-1:0] win_l_i,
  input  logic [HALF_W-1:0] win_u_i,
  input  logic [HALF_W-1:0] nhi_l_i,
  input  logic [HALF_W-1:0] nhi_u_i,
  input  logic [HALF_W-1:0] fhi_l_i,
  input  logic [HALF_W-1:0] fhi_u_i,
  input  logic [HALF_W-1:0] nlo_l_i,
  input  logic [HALF_W-1:0] nlo_u_i,
  input  logic [HALF_W-1:0] flo_l_i,
  input  logic [HALF_W-1:0] flo_u_i,
  output logic              valid_o,
  output logic              done_o,
  output logic              chg_o
);
  localparam cfg_t DEF_CFG = {DEF_FLO, DEF_NLO, DEF_FHI, DEF_NHI, DEF_WIN};

  logic [HALF_W-1:0] lo_half [NFLD];
  logic [HALF_W-1:0] hi_half [NFLD];
  cfg_t              cfg_w;
  logic              start_w, done_w, sat_w;
  logic [CNT_W-1:0]  cnt_w;
  zone_e             zone_w;
  zone_e             zone_q;
  logic              meas_q;

  assign lo_half[F_WIN] = win_l_i;  assign hi_half[F_WIN] = win_u_i;
  assign lo_half[F_NHI] = nhi_l_i;  assign hi_half[F_NHI] = nhi_u_i;
  assign lo_half[F_FHI] = fhi_l_i;  assign hi_half[F_FHI] = fhi_u_i;
  assign lo_half[F_NLO] = nlo_l_i;  assign hi_half[F_NLO] = nlo_u_i;
  assign lo_half[F_FLO] = flo_l_i;  assign hi_half[F_FLO] = flo_u_i;

  mpm_cfg_sel #(.DEF_CFG(DEF_CFG)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_w),
    .use_prog_i (use_prog_i),
    .lo_half_i  (lo_half),
    .hi_half_i  (hi_half),
    .cfg_o      (cfg_w)
  );

  mpm_window_ctr #(.CNT_W(CNT_W)) u_win (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_pulse_i (ref_pulse_i),
    .win_i       (cfg_w[F_WIN]),
    .start_o     (start_w),
    .done_o      (done_w),
    .sat_o       (sat_w),
    .cnt_o       (cnt_w)
  );

  // judged with the limits of the closing window, before reload
  mpm_zone_cls #(.CNT_W(CNT_W)) u_cls (
    .cnt_i  (cnt_w),
    .sat_i  (sat_w),
    .nhi_i  (cfg_w[F_NHI]),
    .fhi_i  (cfg_w[F_FHI]),
    .nlo_i  (cfg_w[F_NLO]),
    .flo_i  (cfg_w[F_FLO]),
    .zone_o (zone_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meas_q <= 1'b0;
      zone_q <= ZONE_GREY;
    end else begin
      meas_q <= done_w;
      if (done_w) zone_q <= zone_w;
    end
  end

  mpm_decision u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .meas_i  (meas_q),
    .zone_i  (zone_q),
    .valid_o (valid_o),
    .done_o  (done_o),
    .chg_o   (chg_o)
  );
endmodule

// File: rtl/mpm_checker.sv
module mpm_checker
  import mpm_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  valid_o,
  input logic  done_o,
  input logic  chg_o,
  input logic  sat_w,
  input zone_e zone_q
);
  // R6
  a_r6_chg_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> done_o);

  // R6
  a_r6_toggle_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o != $past(valid_o)) |-> (chg_o && done_o));

  // R6
  a_r6_chg_is_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> (valid_o != $past(valid_o)));

  // R3
  a_r3_fail_from_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> ($past(zone_q) == ZONE_OUT));

  // R4
  a_r4_pass_from_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> ($past(zone_q) == ZONE_IN));

  // R8
  a_r8_sat_is_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_w |=> (zone_q == ZONE_OUT));
endmodule

bind mp_ref_monitor mpm_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_o (valid_o),
  .done_o  (done_o),
  .chg_o   (chg_o),
  .sat_w   (sat_w),
  .zone_q  (zone_q)
);

// File: tb/mp_ref_monitor_tb.sv
module mp_ref_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NTAB = 14;
  // programmed: window 4, near 36..44, far 32..48; count = 4 * period
  localparam int TAB_P [NTAB] = '{10, 10, 13, 10, 13, 12, 13, 7, 11, 12, 9, 8, 9, 11};
  localparam bit TAB_V [NTAB] = '{0, 1, 1, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 1};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ref_pulse = 1'b0;
  logic use_prog = 1'b1;
  logic [15:0] win_l = 16'd4, nhi_l = 16'd44, fhi_l = 16'd48, nlo_l = 16'd36, flo_l = 16'd32;
  logic [15:0] win_u = '0, nhi_u = '0, fhi_u = '0, nlo_u = '0, flo_u = '0;
  logic valid, done, chg;
  int checks = 0;
  int errors = 0;
  int skip = 0;
  bit prev_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  mp_ref_monitor #(
    .CNT_W(10), .DEF_WIN(32'd2), .DEF_NHI(32'd22), .DEF_FHI(32'd24),
    .DEF_NLO(32'd18), .DEF_FLO(32'd16)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ref_pulse_i(ref_pulse), .use_prog_i(use_prog),
    .win_l_i(win_l), .win_u_i(win_u), .nhi_l_i(nhi_l), .nhi_u_i(nhi_u),
    .fhi_l_i(fhi_l), .fhi_u_i(fhi_u), .nlo_l_i(nlo_l), .nlo_u_i(nlo_u),
    .flo_l_i(flo_l), .flo_u_i(flo_u), .valid_o(valid), .done_o(done), .chg_o(chg)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic send_edge(input int p);
    repeat (p - 1 - skip) tick();
    ref_pulse = 1'b1;
    tick();
    ref_pulse = 1'b0;
    skip = 0;
  endtask

  task automatic end_check(input bit ev, input bit ec, input string req);
    tick();
    chk({req, " R2 done strobe"}, done, 1'b1);
    chk({req, " valid"}, valid, ev);
    chk({req, " chg"}, chg, ec);
    tick();
    chk({req, " R2 done one cycle"}, done, 1'b0);
    skip = 2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    tick(); tick();
    chk("R1 valid in reset", valid, 1'b0);
    chk("R1 done in reset", done, 1'b0);
    chk("R1 chg in reset", chg, 1'b0);
    rst_ni = 1'b1;
    tick();
    chk("R1 valid after release", valid, 1'b0);

    // table walk: R3 R4 R5 with boundary counts
    skip = 0;
    send_edge(10);
    prev_v = 1'b0;
    for (int i = 0; i < NTAB; i++) begin
      for (int e = 0; e < 4; e++) send_edge(TAB_P[i]);
      end_check(TAB_V[i], TAB_V[i] != prev_v, $sformatf("R3/R4/R5 entry %0d", i));
      prev_v = TAB_V[i];
    end

    // R9: window change mid-window applies to the next window only
    win_l = 16'd2;
    send_edge(10);
    send_edge(10);
    tick();
    skip = 1;
    chk("R9 old window still open", done, 1'b0);
    send_edge(10);
    send_edge(10);
    end_check(1'b1, 1'b0, "R9 old window closes");
    send_edge(10);
    send_edge(10);
    end_check(1'b1, 1'b0, "R9 new window / R3 single vote");

    // R7: defaults used when enable is clear
    rst_ni = 1'b0;
    tick(); tick();
    chk("R1 valid in second reset", valid, 1'b0);
    chk("R1 chg in second reset", chg, 1'b0);
    use_prog = 1'b0;
    win_l = 16'd5; nhi_l = 16'd200; fhi_l = 16'd210; nlo_l = 16'd100; flo_l = 16'd90;
    rst_ni = 1'b1;
    tick();
    skip = 0;
    send_edge(10);
    send_edge(10);
    send_edge(10);
    end_check(1'b0, 1'b0, "R7 default window");
    send_edge(10);
    send_edge(10);
    end_check(1'b1, 1'b1, "R7 default limits");

    // R8: edges stop, counter saturates after 1023 cycles
    repeat (1021) tick();
    chk("R8 no early saturation", done, 1'b0);
    tick();
    chk("R8 first saturation done", done, 1'b1);
    chk("R8 first saturation keeps valid", valid, 1'b1);
    repeat (1022) tick();
    chk("R8 restart without edge", done, 1'b0);
    tick();
    chk("R8 second saturation done", done, 1'b1);
    chk("R8 second saturation fails", valid, 1'b0);
    chk("R8 change strobe", chg, 1'b1);
    tick();
    chk("R6 change strobe one cycle", chg, 1'b0);

    finish_run();
  end
endmodule